// File: doc/BRIEF.md
# Fast-Lock Timeout Controller

This block governs a temporary high-gain state of a phase-locked loop. Configuration bits select whether fast-lock is in use, whether the reference and feedback dividers are also cut to a quarter, and whether a timeout counter or a later software write ends the state. A GO bit held in the configuration latch starts high gain. While the state is active, the charge pump runs at four times its normal current and a general-purpose pin is driven low.

In the timed modes, a down-counter is loaded with a coded length when GO rises. The counter steps once per phase-detector comparison strobe. When the count runs out, the block ends high gain on that strobe and sends a one-cycle GO-clear request back to the latch. In the untimed modes, high gain lasts until software writes GO to zero. The exit then waits for the next comparison strobe, so the loop leaves high gain in step with the charge-pump event.

With fast-lock disabled, the block passes configuration straight through. The general-purpose pin drives the select bit, and GO alone picks the pump current. A power-down or initialization reset input puts the counter back into its load state and drops high gain.

Top module: `fastlock_ctrl`

## Requirements
- R1: After reset, with all inputs low, cp_gain_4x=0, div_by4_req=0, gpo_oe=1, gpo_level=0 and go_clear=0.
- R2: With fl_enable=0, gpo_oe=1, gpo_level equals fl_select, cp_gain_4x equals go_bit and div_by4_req=0. In this state go_clear is never asserted, whatever the strobes or timeout settings.
- R3: With fl_enable=1, if go_bit is 0 at one clock edge and 1 at the next, the block enters high gain after that second edge. In high gain, cp_gain_4x=1, gpo_oe=1 and gpo_level=0.
- R4: div_by4_req is 1 only in high gain with fl_select=1 (quarter-divider modes). With fl_select=0, high gain leaves div_by4_req at 0.
- R5: With tmo_enable=1, high gain lasts exactly 4*tmo_code+3 strobes, where tmo_code is unsigned with bit 0 as the LSB. On the edge that samples the last of those strobes, cp_gain_4x falls and go_clear rises. go_clear is high for exactly one cycle.
- R6: With tmo_enable=0, high gain persists across any number of strobes while go_bit stays 1, and go_clear stays 0.
- R7: When go_bit drops during high gain, the exit is synchronous to the strobe. cp_gain_4x stays 1 until the edge that samples the next strobe, and falls at that edge.
- R8: A pwrdn_rst cycle ends high gain and empties the timeout counter. No go_clear follows. A fresh 0-to-1 GO transition is needed to start again, and it then runs a full timeout.
- R9: A new 0-to-1 GO transition during a timed high-gain period reloads the counter, so the full 4*tmo_code+3 strobes count from that point.
- R10: With fl_enable=1 and no high gain, cp_gain_4x=0, div_by4_req=0 and gpo_oe=0 (high impedance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fl_enable | input | 1 | Fast-lock enable bit |
| fl_select | input | 1 | Divider-quarter select; output level when fast-lock is off |
| tmo_enable | input | 1 | Timeout counter enable |
| tmo_code | input | CODE_W | Coded timeout length |
| go_bit | input | 1 | GO bit from the configuration latch |
| pd_strobe | input | 1 | One-cycle pulse per phase-detector comparison |
| pwrdn_rst | input | 1 | Power-down or initialization reset pulse |
| cp_gain_4x | output | 1 | Charge-pump current select, 1 = four times |
| div_by4_req | output | 1 | Request to cut divider ratios to a quarter |
| gpo_level | output | 1 | General-purpose output level |
| gpo_oe | output | 1 | General-purpose output drive enable |
| go_clear | output | 1 | One-cycle request to clear the GO bit |

## Verification
The bench builds the block with its default parameters: a 4-bit code, a step of 4 and a bias of 3. This puts the whole code space within reach, so every timeout length from 3 to 63 strobes is run in both the full-ratio and the quarter-ratio timed modes. For each run, the bench checks that the GO-clear pulse falls on the strobe given by 4*code+3. The small configuration also allows every combination of select and GO to be driven with fast-lock disabled. The untimed modes are held across more strobes than the longest timeout, and separate runs cover power-down in mid-count and a GO re-write that restarts the count.

// File: rtl/fl_pkg.sv
package fl_pkg;

    typedef enum logic [1:0] {
        FL_MANUAL_FULL = 2'd0,
        FL_TIMED_FULL  = 2'd1,
        FL_MANUAL_QTR  = 2'd2,
        FL_TIMED_QTR   = 2'd3
    } fl_mode_e;

    typedef struct packed {
        logic     enable;
        logic     quarter;
        logic     timed;
        logic     sel;
        fl_mode_e mode;
    } fl_cfg_t;

    typedef struct packed {
        logic gain4x;
        logic div_q;
        logic gpo_lvl;
        logic gpo_oe;
    } fl_out_t;

    function automatic fl_out_t fl_drive(input fl_cfg_t cfg, input logic hg, input logic go);
        fl_out_t o;
        if (!cfg.enable) begin
            o.gain4x  = go;
            o.div_q   = 1'b0;
            o.gpo_lvl = cfg.sel;
            o.gpo_oe  = 1'b1;
        end else if (hg) begin
            o.gain4x  = 1'b1;
            o.div_q   = cfg.quarter;
            o.gpo_lvl = 1'b0;
            o.gpo_oe  = 1'b1;
        end else begin
            o.gain4x  = 1'b0;
            o.div_q   = 1'b0;
            o.gpo_lvl = 1'b0;
            o.gpo_oe  = 1'b0;
        end
        return o;
    endfunction

endpackage

// File: rtl/fl_mode_decode.sv
module fl_mode_decode
    import fl_pkg::*;
(
    input  logic    en,
    input  logic    sel,
    input  logic    tmo,
    output fl_cfg_t cfg
);
    always_comb begin
        cfg.enable  = en;
        cfg.sel     = sel;
        cfg.quarter = en & sel;
        cfg.timed   = en & tmo;
        cfg.mode    = fl_mode_e'({sel, tmo});
    end
endmodule

// File: rtl/fl_timeout_ctr.sv
module fl_timeout_ctr #(
    parameter int CODE_W = 4,
    parameter int STEP   = 4,
    parameter int BIAS   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic              strobe,
    input  logic [CODE_W-1:0] code,
    output logic              expire,
    output logic              running
);
    localparam int MAXLEN = STEP * ((1 << CODE_W) - 1) + BIAS;
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    logic [CNT_W-1:0] cnt;

    function automatic logic [CNT_W-1:0] span(input logic [CODE_W-1:0] c);
        return CNT_W'(STEP * int'(c) + BIAS);
    endfunction

    assign expire = running & strobe & (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= span(code);
            running <= 1'b1;
        end else if (running && strobe) begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) running <= 1'b0;
        end
    end
endmodule

// File: rtl/fl_gain_ctl.sv
module fl_gain_ctl
    import fl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  fl_cfg_t cfg,
    input  logic    go,
    input  logic    strobe,
    input  logic    expire,
    output logic    go_rise,
    output logic    tmr_clear,
    output logic    go_clear,
    output fl_out_t outs
);
    logic go_q;
    logic hg;
    logic sw_exit;

    assign go_rise   = go & ~go_q & ~flush;
    assign sw_exit   = hg & strobe & ~go;
    assign tmr_clear = flush | ~cfg.timed | sw_exit;

    always_ff @(posedge clk) begin
        if (rst) go_q <= 1'b0;
        else     go_q <= go;
    end

    always_ff @(posedge clk) begin
        if (rst || flush || !cfg.enable)       hg <= 1'b0;
        else if (go_rise)                       hg <= 1'b1;
        else if (strobe && (expire || !go))     hg <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) go_clear <= 1'b0;
        else     go_clear <= expire & cfg.timed & ~flush & ~go_rise;
    end

    assign outs = fl_drive(cfg, hg, go);
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl
    import fl_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int STEP   = 4,
    parameter int BIAS   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fl_enable,
    input  logic              fl_select,
    input  logic              tmo_enable,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic              go_bit,
    input  logic              pd_strobe,
    input  logic              pwrdn_rst,
    output logic              cp_gain_4x,
    output logic              div_by4_req,
    output logic              gpo_level,
    output logic              gpo_oe,
    output logic              go_clear
);
    fl_cfg_t cfg;
    fl_out_t outs;
    logic    go_rise;
    logic    tmr_clear;
    logic    expire;
    logic    running;

    fl_mode_decode u_dec (
        .en  (fl_enable),
        .sel (fl_select),
        .tmo (tmo_enable),
        .cfg (cfg)
    );

    fl_timeout_ctr #(.CODE_W(CODE_W), .STEP(STEP), .BIAS(BIAS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (tmr_clear),
        .load    (go_rise & cfg.timed),
        .strobe  (pd_strobe),
        .code    (tmo_code),
        .expire  (expire),
        .running (running)
    );

    fl_gain_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .flush     (pwrdn_rst),
        .cfg       (cfg),
        .go        (go_bit),
        .strobe    (pd_strobe),
        .expire    (expire & running),
        .go_rise   (go_rise),
        .tmr_clear (tmr_clear),
        .go_clear  (go_clear),
        .outs      (outs)
    );

    assign cp_gain_4x  = outs.gain4x;
    assign div_by4_req = outs.div_q;
    assign gpo_level   = outs.gpo_lvl;
    assign gpo_oe      = outs.gpo_oe;
endmodule

// File: rtl/fastlock_ctrl_chk.sv
module fastlock_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic fl_enable,
    input logic fl_select,
    input logic go_bit,
    input logic pd_strobe,
    input logic pwrdn_rst,
    input logic cp_gain_4x,
    input logic div_by4_req,
    input logic gpo_level,
    input logic gpo_oe,
    input logic go_clear
);
    p_clear_single_r5: assert property (@(posedge clk) disable iff (rst)
        go_clear |=> !go_clear);

    p_clear_ends_gain_r5: assert property (@(posedge clk) disable iff (rst)
        (go_clear && fl_enable) |-> !cp_gain_4x);

    p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
        !fl_enable |-> (gpo_oe && gpo_level == fl_select && cp_gain_4x == go_bit && !div_by4_req));

    p_quarter_only_r4: assert property (@(posedge clk) disable iff (rst)
        div_by4_req |-> (fl_enable && fl_select && cp_gain_4x));

    p_exit_on_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (fl_enable && $past(fl_enable) && !$past(rst) && $fell(cp_gain_4x))
            |-> ($past(pd_strobe) || $past(pwrdn_rst)));

    p_pwrdn_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        pwrdn_rst |=> (!go_clear && !(fl_enable && cp_gain_4x && $stable(fl_enable))));

    p_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (fl_enable && go_bit && !pwrdn_rst && !$past(go_bit) && !$past(rst))
            |=> (!fl_enable || cp_gain_4x));
endmodule

bind fastlock_ctrl fastlock_ctrl_chk u_chk (.*);

// File: tb/sim_fastlock_ctrl.sv
module sim_fastlock_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fl_enable = 1'b0;
    logic       fl_select = 1'b0;
    logic       tmo_enable = 1'b0;
    logic [3:0] tmo_code = 4'd0;
    logic       go_bit = 1'b0;
    logic       pd_strobe = 1'b0;
    logic       pwrdn_rst = 1'b0;
    logic       cp_gain_4x, div_by4_req, gpo_level, gpo_oe, go_clear;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fastlock_ctrl u0 (
        .clk(clk), .rst(rst), .fl_enable(fl_enable), .fl_select(fl_select),
        .tmo_enable(tmo_enable), .tmo_code(tmo_code), .go_bit(go_bit),
        .pd_strobe(pd_strobe), .pwrdn_rst(pwrdn_rst), .cp_gain_4x(cp_gain_4x),
        .div_by4_req(div_by4_req), .gpo_level(gpo_level), .gpo_oe(gpo_oe),
        .go_clear(go_clear)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Strobe n times; record the strobe index of the first clear and of the first gain drop.
    task automatic pulses(input int n, output int first_clr, output int n_clr, output int first_drop);
        first_clr = 0; n_clr = 0; first_drop = 0;
        for (int k = 1; k <= n; k++) begin
            pd_strobe = 1'b1;
            cyc();
            pd_strobe = 1'b0;
            if (go_clear) begin
                n_clr++;
                if (first_clr == 0) first_clr = k;
                go_bit = 1'b0;
            end
            if (!cp_gain_4x && first_drop == 0) first_drop = k;
            cyc();
            if (go_clear) n_clr++;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int fc, nc, fd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk(cp_gain_4x == 0, "R1 gain", cp_gain_4x, 0);
        chk(div_by4_req == 0, "R1 div", div_by4_req, 0);
        chk(gpo_oe == 1 && gpo_level == 0, "R1 gpo", {gpo_oe, gpo_level}, 2);
        chk(go_clear == 0, "R1 clear", go_clear, 0);

        // R2 disabled pass-through, all select/GO combinations
        for (int s = 0; s < 2; s++) begin
            for (int g = 0; g < 2; g++) begin
                fl_select = s[0]; go_bit = g[0];
                cyc();
                chk(gpo_oe == 1 && gpo_level == s[0], "R2 gpo", gpo_level, s);
                chk(cp_gain_4x == g[0], "R2 gain", cp_gain_4x, g);
                chk(div_by4_req == 0, "R2 div", div_by4_req, 0);
            end
        end
        go_bit = 0; tmo_enable = 1; tmo_code = 0; fl_select = 0;
        cyc();
        go_bit = 1;
        cyc();
        pulses(10, fc, nc, fd);
        chk(nc == 0, "R2 no clear when disabled", nc, 0);
        chk(cp_gain_4x == 1, "R2 gain follows go", cp_gain_4x, 1);
        go_bit = 0;
        cyc();

        // R5 exhaustive timeout sweep in both timed modes
        for (int q = 0; q < 2; q++) begin
            for (int c = 0; c < 16; c++) begin
                int len;
                len = 4 * c + 3;
                fl_enable = 1; fl_select = q[0]; tmo_enable = 1; tmo_code = c[3:0]; go_bit = 0;
                cyc();
                chk(cp_gain_4x == 0 && gpo_oe == 0 && div_by4_req == 0, "R10 idle", {cp_gain_4x, gpo_oe, div_by4_req}, 0);
                go_bit = 1;
                cyc();
                chk(cp_gain_4x == 1 && gpo_oe == 1 && gpo_level == 0, "R3 entry", {cp_gain_4x, gpo_oe, gpo_level}, 6);
                chk(div_by4_req == q[0], "R4 divider", div_by4_req, q);
                pulses(len + 2, fc, nc, fd);
                chk(fc == len, "R5 clear strobe", fc, len);
                chk(nc == 1, "R5 single pulse", nc, 1);
                chk(fd == len, "R5 gain drop strobe", fd, len);
            end
        end

        // R6 / R7 manual modes
        for (int q = 0; q < 2; q++) begin
            fl_select = q[0]; tmo_enable = 0; tmo_code = 4'hF; go_bit = 0;
            cyc();
            go_bit = 1;
            cyc();
            chk(div_by4_req == q[0], "R4 manual divider", div_by4_req, q);
            pulses(70, fc, nc, fd);
            chk(nc == 0, "R6 no clear", nc, 0);
            chk(fd == 0, "R6 gain held", fd, 0);
            go_bit = 0;
            cyc(); cyc(); cyc();
            chk(cp_gain_4x == 1, "R7 held until strobe", cp_gain_4x, 1);
            pulses(1, fc, nc, fd);
            chk(fd == 1, "R7 drop on strobe", fd, 1);
            chk(gpo_oe == 0, "R10 after exit", gpo_oe, 0);
        end

        // R8 power-down in mid-count
        fl_select = 1; tmo_enable = 1; tmo_code = 0; go_bit = 0;
        cyc();
        go_bit = 1;
        cyc();
        pulses(2, fc, nc, fd);
        chk(nc == 0, "R8 pre-pwrdn", nc, 0);
        pwrdn_rst = 1;
        cyc();
        pwrdn_rst = 0;
        chk(cp_gain_4x == 0 && div_by4_req == 0, "R8 gain off", cp_gain_4x, 0);
        pulses(5, fc, nc, fd);
        chk(nc == 0, "R8 no clear after pwrdn", nc, 0);
        chk(cp_gain_4x == 0, "R8 stays off", cp_gain_4x, 0);
        go_bit = 0;
        cyc();
        go_bit = 1;
        cyc();
        pulses(5, fc, nc, fd);
        chk(fc == 3, "R8 rearm full count", fc, 3);

        // R9 restart by a new GO write
        fl_select = 0; tmo_code = 1; go_bit = 0;
        cyc();
        go_bit = 1;
        cyc();
        pulses(4, fc, nc, fd);
        chk(nc == 0, "R9 before restart", nc, 0);
        go_bit = 0;
        cyc();
        go_bit = 1;
        cyc();
        chk(cp_gain_4x == 1, "R9 gain kept", cp_gain_4x, 1);
        pulses(10, fc, nc, fd);
        chk(fc == 7, "R9 restarted count", fc, 7);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule